// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block decides where instruction fetch goes next in a core with a fixed 32-bit instruction word and a load/store programming model. Each cycle the core presents the address of the current instruction, the instruction word and the values of its two source registers. The unit classifies the instruction and evaluates any branch condition. It then produces the following fetch address, a redirect flag, the return address with its write enable, and an illegal-opcode flag.

Conditions never use a subtractor. Two-register branches compare for equality or inequality only. One-register branches look at the sign bit and a zero reduction of the first source. Targets come from three sources: PC-relative offsets for conditional branches, a 26-bit region-relative index for absolute jumps, and the first source register for indirect jumps. There is no delay slot, so a redirect applies to the very next fetch. All outputs are registered, so results appear one clock after the inputs are sampled.

Top module: `bru_next_pc`

Encodings use opcode = instr[31:26], rs = instr[25:21], rt = instr[20:16], offset = instr[15:0], jump index = instr[25:0], function code = instr[5:0]. `rs_val_i` is the value of register rs and `rt_val_i` is the value of register rt.

## Requirements
- R1: While rst_n is low at a rising clock edge, every output becomes zero after that edge.
- R2: The outputs change only at a rising edge and reflect the inputs sampled at that edge, one cycle of latency.
- R3: Recognised non-control instructions do not redirect: opcodes 0x08..0x0F and 0x20..0x2F, and opcode 0x00 with a function code other than 0x08/0x09. For these the next PC is PC+4, taken is 0, link enable is 0 and illegal is 0.
- R4: Opcode 0x04 is taken when rs_val equals rt_val, and opcode 0x05 is taken when they differ. A taken branch goes to PC+4 plus the sign-extended 16-bit offset shifted left by 2, with the sum wrapping modulo 2^32.
- R5: Zero-compare branches treat rs_val as signed two's complement. Opcode 0x06 is taken when rs_val <= 0 and opcode 0x07 when rs_val > 0. Opcode 0x01 with rt = 0 is taken when rs_val < 0, and with rt = 1 when rs_val >= 0. The target is formed as in R4.
- R6: A conditional branch whose condition is false gives next PC = PC+4 and taken = 0.
- R7: Opcodes 0x02 and 0x03 always redirect to {upper 4 bits of PC+4, 26-bit index, 2'b00}, with taken = 1.
- R8: Opcode 0x00 with function code 0x08 or 0x09 always redirects to rs_val, with taken = 1.
- R9: Opcode 0x03, and opcode 0x00 with function 0x09, set link enable = 1 with link value = PC+4 (for register 31). Every other instruction gives link enable = 0.
- R10: Any other opcode, or opcode 0x01 with rt other than 0 or 1, sets illegal = 1 with next PC = PC+4, taken = 0 and link enable = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of source register rs |
| rt_val_i | input | 32 | Value of source register rt |
| npc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Fetch is redirected away from PC+4 |
| link_en_o | output | 1 | Write return address to register 31 |
| link_val_o | output | 32 | Return address (PC+4) |
| illegal_o | output | 1 | Opcode not recognised |

## Verification
The unit holds no state beyond its output register, so a fault in classification or condition logic shows up on the ports exactly one cycle after the offending instruction is presented. A misdecoded opcode appears as a wrong taken, illegal or link flag for that single cycle. A wrong sign or zero test appears as a target that differs from PC+4 where it should not, or the reverse. A broken offset or region splice shows only for particular bit patterns. The directed cases therefore use negative offsets, wrap-around addresses, region-boundary PCs and the three values zero, positive and negative for every zero-compare form.

// File: rtl/bru_pkg.sv
// Package: shared constants and the control-flow class type for the
// next-PC unit. Assumes 32-bit instruction words with a 6-bit opcode.
package bru_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int REG_W   = 5;
    localparam int OFS_W   = 16;
    localparam int IDX_W   = 26;
    localparam int REGION_W = 4;

    localparam logic [OPC_W-1:0] OP_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OP_ZCMP  = 6'h01;
    localparam logic [OPC_W-1:0] OP_JMP   = 6'h02;
    localparam logic [OPC_W-1:0] OP_JMPL  = 6'h03;
    localparam logic [OPC_W-1:0] OP_BREQ  = 6'h04;
    localparam logic [OPC_W-1:0] OP_BRNE  = 6'h05;
    localparam logic [OPC_W-1:0] OP_BRLEZ = 6'h06;
    localparam logic [OPC_W-1:0] OP_BRGTZ = 6'h07;

    localparam logic [FN_W-1:0] FN_JREG  = 6'h08;
    localparam logic [FN_W-1:0] FN_JREGL = 6'h09;

    localparam logic [REG_W-1:0] RT_LTZ = 5'd0;
    localparam logic [REG_W-1:0] RT_GEZ = 5'd1;

    typedef enum logic [3:0] {
        CF_SEQ,
        CF_EQ,
        CF_NE,
        CF_LEZ,
        CF_GTZ,
        CF_LTZ,
        CF_GEZ,
        CF_JABS,
        CF_JREG,
        CF_BAD
    } cf_kind_e;
endpackage

// File: rtl/bru_decode.sv
// Module: classifies an instruction into a control-flow kind and says
// whether it writes a return address. Assumes fields are pre-sliced.
module bru_decode
    import bru_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic [REG_W-1:0] rt_sel,
    input  logic [FN_W-1:0]  fn,
    output cf_kind_e         kind,
    output logic             link
);
    // Map opcode, rt selector and function code onto a kind.
    always_comb begin
        kind = CF_BAD;
        link = 1'b0;
        unique casez (opc)
            OP_REG: begin
                if (fn == FN_JREG) begin
                    kind = CF_JREG;
                end else if (fn == FN_JREGL) begin
                    kind = CF_JREG;
                    link = 1'b1;
                end else begin
                    kind = CF_SEQ;
                end
            end
            OP_ZCMP: begin
                if (rt_sel == RT_LTZ)      kind = CF_LTZ;
                else if (rt_sel == RT_GEZ) kind = CF_GEZ;
                else                       kind = CF_BAD;
            end
            OP_JMP:   kind = CF_JABS;
            OP_JMPL: begin
                kind = CF_JABS;
                link = 1'b1;
            end
            OP_BREQ:  kind = CF_EQ;
            OP_BRNE:  kind = CF_NE;
            OP_BRLEZ: kind = CF_LEZ;
            OP_BRGTZ: kind = CF_GTZ;
            6'b001???: kind = CF_SEQ;
            6'b10????: kind = CF_SEQ;
            default:  kind = CF_BAD;
        endcase
    end
endmodule

// File: rtl/bru_cond.sv
// Module: evaluates whether the classified instruction redirects fetch.
// Uses only an equality compare, the sign bit and a zero reduction.
module bru_cond
    import bru_pkg::*;
#(
    parameter int DW = 32
) (
    input  cf_kind_e        kind,
    input  logic [DW-1:0]   rs_val,
    input  logic [DW-1:0]   rt_val,
    output logic            take
);
    logic rs_zero;
    logic rs_neg;
    logic same;

    // Cheap predicates shared by all condition forms.
    always_comb begin
        rs_zero = ~|rs_val;
        rs_neg  = rs_val[DW-1];
        same    = (rs_val == rt_val);
    end

    // Select the predicate that belongs to the kind.
    always_comb begin
        unique case (kind)
            CF_EQ:   take = same;
            CF_NE:   take = ~same;
            CF_LEZ:  take = rs_neg | rs_zero;
            CF_GTZ:  take = ~rs_neg & ~rs_zero;
            CF_LTZ:  take = rs_neg;
            CF_GEZ:  take = ~rs_neg;
            CF_JABS: take = 1'b1;
            CF_JREG: take = 1'b1;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target.sv
// Module: forms the sequential, PC-relative, region-absolute and
// register targets and picks the next PC. Assumes AW > 28.
module bru_target
    import bru_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    pc,
    input  logic [IDX_W-1:0] idx,
    input  logic [AW-1:0]    rs_val,
    input  cf_kind_e         kind,
    input  logic             take,
    output logic [AW-1:0]    seq_pc,
    output logic [AW-1:0]    npc
);
    localparam int EXT_W  = AW - OFS_W - 2;
    localparam int KEEP_W = AW - IDX_W - 2;

    logic [OFS_W-1:0] ofs;
    logic [AW-1:0]    rel_pc;
    logic [AW-1:0]    abs_pc;

    // Compute every candidate target in parallel.
    always_comb begin
        ofs    = idx[OFS_W-1:0];
        seq_pc = pc + AW'(4);
        rel_pc = seq_pc + {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
        abs_pc = {seq_pc[AW-1 -: KEEP_W], idx, 2'b00};
    end

    // Choose the candidate named by the kind when the condition holds.
    always_comb begin
        npc = seq_pc;
        if (take) begin
            unique case (kind)
                CF_EQ, CF_NE, CF_LEZ, CF_GTZ, CF_LTZ, CF_GEZ: npc = rel_pc;
                CF_JABS: npc = abs_pc;
                CF_JREG: npc = rs_val;
                default: npc = seq_pc;
            endcase
        end
    end
endmodule

// File: rtl/bru_next_pc.sv
// Module: top of the next-PC unit. Decodes, evaluates, builds targets
// and registers all results. Assumes a synchronous active-low reset.
module bru_next_pc
    import bru_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     pc_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [AW-1:0]     rs_val_i,
    input  logic [AW-1:0]     rt_val_i,
    output logic [AW-1:0]     npc_o,
    output logic              taken_o,
    output logic              link_en_o,
    output logic [AW-1:0]     link_val_o,
    output logic              illegal_o
);
    localparam int HI_W = AW - IDX_W - 2;

    cf_kind_e      kind;
    logic          link;
    logic          take;
    logic [AW-1:0] seq_pc;
    logic [AW-1:0] npc_c;
    logic [HI_W-1:0] region_hi;

    bru_decode u_dec (
        .opc    (instr_i[31:26]),
        .rt_sel (instr_i[20:16]),
        .fn     (instr_i[5:0]),
        .kind   (kind),
        .link   (link)
    );

    bru_cond #(.DW(AW)) u_cond (
        .kind   (kind),
        .rs_val (rs_val_i),
        .rt_val (rt_val_i),
        .take   (take)
    );

    bru_target #(.AW(AW)) u_tgt (
        .pc     (pc_i),
        .idx    (instr_i[25:0]),
        .rs_val (rs_val_i),
        .kind   (kind),
        .take   (take),
        .seq_pc (seq_pc),
        .npc    (npc_c)
    );

    // Region bits of PC+4 kept for the jump-target check.
    always_comb region_hi = seq_pc[AW-1 -: HI_W];

    // Register the resolved results; clear them in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npc_o      <= '0;
            taken_o    <= 1'b0;
            link_en_o  <= 1'b0;
            link_val_o <= '0;
            illegal_o  <= 1'b0;
        end else begin
            npc_o      <= npc_c;
            taken_o    <= take;
            link_en_o  <= link;
            link_val_o <= seq_pc;
            illegal_o  <= (kind == CF_BAD);
        end
    end

    AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && link_en_o) |-> (link_val_o == $past(pc_i) + AW'(4))); // R9
    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> (npc_o == $past(pc_i) + AW'(4))); // R6
    AST_BAD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!taken_o && !link_en_o)); // R10
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken_o, illegal_o})); // R10
    AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(instr_i[31:26]) == OP_JMP || $past(instr_i[31:26]) == OP_JMPL))
        |-> (taken_o && npc_o[AW-1 -: HI_W] == $past(region_hi))); // R7
    AST_JREG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(instr_i[31:26]) == OP_REG &&
         ($past(instr_i[5:0]) == FN_JREG || $past(instr_i[5:0]) == FN_JREGL))
        |-> (taken_o && npc_o == $past(rs_val_i))); // R8
endmodule

// File: tb/sim_bru_next_pc.sv
`timescale 1ns/100ps
module sim_bru_next_pc;
    logic        clk;
    logic        rst_n;
    logic [31:0] pc_i;
    logic [31:0] instr_i;
    logic [31:0] rs_val_i;
    logic [31:0] rt_val_i;
    logic [31:0] npc_o;
    logic        taken_o;
    logic        link_en_o;
    logic [31:0] link_val_o;
    logic        illegal_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    bru_next_pc u0 (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .npc_o(npc_o),
        .taken_o(taken_o), .link_en_o(link_en_o), .link_val_o(link_val_o),
        .illegal_o(illegal_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] ofs);
        return {op, rs, rt, ofs};
    endfunction

    function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction

    function automatic logic [31:0] mk_r(input logic [4:0] rs, input logic [5:0] fn);
        return {6'h00, rs, 5'd0, 5'd0, 5'd0, fn};
    endfunction

    // Present one instruction and wait until its registered result is visible.
    task automatic issue(input logic [31:0] pc, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b;
        @(negedge clk);
    endtask

    task automatic expect_all(input string req, input logic [31:0] npc, input logic tk,
                              input logic ln, input logic [31:0] lv, input logic bad);
        chk(req, "npc", npc_o, npc);
        chk(req, "taken", {31'd0, taken_o}, {31'd0, tk});
        chk(req, "link_en", {31'd0, link_en_o}, {31'd0, ln});
        if (ln) chk(req, "link_val", link_val_o, lv);
        chk(req, "illegal", {31'd0, illegal_o}, {31'd0, bad});
    endtask

    task automatic t_reset;
        // R1: reset clears outputs even with a linking jump presented
        @(negedge clk);
        rst_n = 1'b0;
        pc_i = 32'h1234_5670; instr_i = mk_j(6'h03, 26'h155_5555);
        rs_val_i = 32'hFFFF_FFFF; rt_val_i = 32'h1;
        @(negedge clk); @(negedge clk);
        chk("R1", "npc", npc_o, 32'h0);
        chk("R1", "flags", {29'd0, taken_o, link_en_o, illegal_o}, 32'h0);
        chk("R1", "link_val", link_val_o, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_seq;
        issue(32'h0000_1000, mk_i(6'h08, 5'd1, 5'd2, 16'h8000), 32'h0, 32'h0);
        expect_all("R3", 32'h0000_1004, 1'b0, 1'b0, 32'h0, 1'b0);
        issue(32'h0000_2000, mk_i(6'h23, 5'd3, 5'd4, 16'hFFFF), 32'h5, 32'h5);
        expect_all("R3", 32'h0000_2004, 1'b0, 1'b0, 32'h0, 1'b0);
        issue(32'h0000_3000, mk_r(5'd7, 6'h20), 32'h77, 32'h0);
        expect_all("R3", 32'h0000_3004, 1'b0, 1'b0, 32'h0, 1'b0);
        issue(32'h0000_3100, mk_i(6'h2F, 5'd0, 5'd0, 16'h0), 32'h0, 32'h0);
        expect_all("R3", 32'h0000_3104, 1'b0, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_equal;
        // R4 taken forward, R6 not taken, R4 backward, R6 bne on equal
        issue(32'h0000_2000, mk_i(6'h04, 5'd1, 5'd2, 16'd3), 32'hA5A5_0001, 32'hA5A5_0001);
        expect_all("R4", 32'h0000_2010, 1'b1, 1'b0, 32'h0, 1'b0);
        issue(32'h0000_2000, mk_i(6'h04, 5'd1, 5'd2, 16'd3), 32'hA5A5_0001, 32'hA5A5_0003);
        expect_all("R6", 32'h0000_2004, 1'b0, 1'b0, 32'h0, 1'b0);
        issue(32'h0000_2000, mk_i(6'h05, 5'd1, 5'd2, 16'hFFFC), 32'h1, 32'h8000_0001);
        expect_all("R4", 32'h0000_1FF4, 1'b1, 1'b0, 32'h0, 1'b0);
        issue(32'h0000_2000, mk_i(6'h05, 5'd1, 5'd2, 16'hFFFC), 32'h9, 32'h9);
        expect_all("R6", 32'h0000_2004, 1'b0, 1'b0, 32'h0, 1'b0);
        // R4: wrap-around past the top of the address space
        issue(32'hFFFF_FFF8, mk_i(6'h04, 5'd0, 5'd0, 16'd2), 32'h0, 32'h0);
        expect_all("R4", 32'h0000_0004, 1'b1, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_zero;
        logic [31:0] vals [3];
        logic        exp_t [4][3];
        logic [31:0] ins [4];
        vals[0] = 32'h0; vals[1] = 32'h5; vals[2] = 32'hFFFF_FFFB;
        ins[0] = mk_i(6'h06, 5'd4, 5'd0, 16'd8);   // rs <= 0
        ins[1] = mk_i(6'h07, 5'd4, 5'd0, 16'd8);   // rs > 0
        ins[2] = mk_i(6'h01, 5'd4, 5'd0, 16'd8);   // rs < 0
        ins[3] = mk_i(6'h01, 5'd4, 5'd1, 16'd8);   // rs >= 0
        exp_t[0][0] = 1; exp_t[0][1] = 0; exp_t[0][2] = 1;
        exp_t[1][0] = 0; exp_t[1][1] = 1; exp_t[1][2] = 0;
        exp_t[2][0] = 0; exp_t[2][1] = 0; exp_t[2][2] = 1;
        exp_t[3][0] = 1; exp_t[3][1] = 1; exp_t[3][2] = 0;
        for (int k = 0; k < 4; k++) begin
            for (int v = 0; v < 3; v++) begin
                // rt value chosen to differ from rs; zero tests must ignore it
                issue(32'h0000_4000, ins[k], vals[v], ~vals[v]);
                expect_all("R5", exp_t[k][v] ? 32'h0000_4024 : 32'h0000_4004,
                           exp_t[k][v], 1'b0, 32'h0, 1'b0);
            end
        end
    endtask

    task automatic t_jump;
        issue(32'h3000_0100, mk_j(6'h02, 26'h012_3456), 32'h0, 32'h0);
        expect_all("R7", 32'h3048_D158, 1'b1, 1'b0, 32'h0, 1'b0);
        // R7: region taken from PC+4, which crosses into the next region
        issue(32'h4FFF_FFFC, mk_j(6'h02, 26'h3FF_FFFF), 32'h0, 32'h0);
        expect_all("R7", 32'h5FFF_FFFC, 1'b1, 1'b0, 32'h0, 1'b0);
        issue(32'h0000_5000, mk_r(5'd9, 6'h08), 32'h0000_ABCD, 32'h1);
        expect_all("R8", 32'h0000_ABCD, 1'b1, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_link;
        issue(32'h0000_0100, mk_j(6'h03, 26'h000_0040), 32'h0, 32'h0);
        expect_all("R9", 32'h0000_0100, 1'b1, 1'b1, 32'h0000_0104, 1'b0);
        issue(32'h0000_0200, mk_r(5'd8, 6'h09), 32'h0000_8000, 32'h0);
        expect_all("R9", 32'h0000_8000, 1'b1, 1'b1, 32'h0000_0204, 1'b0);
        chk("R8", "jreg link target", npc_o, 32'h0000_8000);
        issue(32'h0000_0300, mk_i(6'h04, 5'd0, 5'd0, 16'd1), 32'h0, 32'h0);
        expect_all("R9", 32'h0000_0308, 1'b1, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_illegal;
        issue(32'h0000_0500, 32'hFC00_0000, 32'h0, 32'h0);
        expect_all("R10", 32'h0000_0504, 1'b0, 1'b0, 32'h0, 1'b1);
        issue(32'h0000_0600, mk_i(6'h10, 5'd0, 5'd0, 16'd4), 32'h0, 32'h0);
        expect_all("R10", 32'h0000_0604, 1'b0, 1'b0, 32'h0, 1'b1);
        issue(32'h0000_0700, mk_i(6'h01, 5'd2, 5'd5, 16'd4), 32'h8000_0000, 32'h0);
        expect_all("R10", 32'h0000_0704, 1'b0, 1'b0, 32'h0, 1'b1);
    endtask

    task automatic t_latency;
        // R2: new inputs do not reach the outputs before the next rising edge
        issue(32'h0000_0800, mk_j(6'h02, 26'h000_0100), 32'h0, 32'h0);
        pc_i = 32'h0000_0900; instr_i = 32'hFC00_0000;
        #1;
        chk("R2", "npc held", npc_o, 32'h0000_0400);
        chk("R2", "illegal held", {31'd0, illegal_o}, 32'h0);
        @(negedge clk);
        chk("R2", "npc updated", npc_o, 32'h0000_0904);
        chk("R2", "illegal updated", {31'd0, illegal_o}, 32'h1);
    endtask

    initial begin
        rst_n = 1'b0; pc_i = '0; instr_i = '0; rs_val_i = '0; rt_val_i = '0;
        t_reset();
        t_seq();
        t_equal();
        t_zero();
        t_jump();
        t_link();
        t_illegal();
        t_latency();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule